// File: doc/BRIEF.md
# Branch Target Buffer Fetch Predictor

This block sits beside the instruction cache in the fetch stage and picks the next fetch address. It uses the current fetch PC to read a direct-mapped table in the same cycle that the cache is read. A valid entry whose tag matches the PC counts as a predicted-taken branch, and its stored target becomes the next fetch PC. Any other PC is treated as a plain instruction, and fetch continues at the PC plus the instruction size.

Branch direction is not stored. A PC has an entry only while the block predicts it as taken. The execute stage reports each resolved branch on a resolve port. That report carries the branch PC, whether it was taken, its real target, and the prediction the fetch stage made for it (hit flag and predicted target). From this report the block adds an entry for a taken branch that missed and replaces the target of a hit that went somewhere else. It removes the entry of a hit that turned out not taken. On every misprediction it raises a flush with the correct restart address, in the same cycle as the report.

Top module: `btb_fetch_predictor`

## Requirements
- R1: After reset every entry is invalid, so every fetch PC misses (`lookup_hit`=0, `next_pc`=`fetch_pc`+4).
- R2: On a miss, `lookup_hit` is 0 and `next_pc` equals `fetch_pc`+4, in the same cycle.
- R3: The entry is selected by `fetch_pc[7:2]`, and the tag is `fetch_pc[31:8]`. A PC that shares the index with a stored branch but has a different tag misses.
- R4: When a valid entry has a matching tag, `lookup_hit` is 1 and `next_pc` is the stored target, in the same cycle.
- R5: A resolve that was not predicted (`resolve_pred_hit`=0) and was taken writes an entry holding the PC's tag and `resolve_target`. It also raises `flush` with `redirect_pc`=`resolve_target` in that cycle. Fetches of that PC hit from the next cycle on.
- R6: A resolve that was predicted but not taken raises `flush` with `redirect_pc`=`resolve_pc`+4. If the entry at that index still holds that PC's tag, the entry is cleared. An entry holding a different tag is left in place.
- R7: A resolve that was predicted, taken, and whose target equals `resolve_pred_target` raises no flush and leaves the table unchanged.
- R8: A resolve that was predicted and taken, but whose target differs from the predicted one, raises `flush` with `redirect_pc`=`resolve_target`. It also replaces the stored target.
- R9: A resolve that was neither predicted nor taken raises no flush and leaves the table unchanged.
- R10: When a lookup and a resolve update address the same entry in one cycle, the lookup sees the contents from before the update.
- R11: `flush` is 0 in any cycle where `resolve_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | PC being fetched this cycle |
| lookup_hit | output | 1 | Fetch PC predicted as a taken branch |
| next_pc | output | 32 | Predicted next fetch PC |
| resolve_valid | input | 1 | A branch resolves this cycle |
| resolve_pc | input | 32 | PC of the resolving branch |
| resolve_taken | input | 1 | Actual direction |
| resolve_target | input | 32 | Actual target when taken |
| resolve_pred_hit | input | 1 | Whether fetch hit for this branch |
| resolve_pred_target | input | 32 | Target predicted at fetch |
| flush | output | 1 | Kill wrong-path work and restart fetch |
| redirect_pc | output | 32 | Restart address when flush is 1 |

## Verification
Two things can happen in the same cycle: a lookup on the fetch side and a table write from the resolve side. The most important case is when both address the same entry. Directed steps present `fetch_pc` equal to `resolve_pc` during an insert and during a delete. The bench expects the lookup result computed from the table as it was before that cycle's write, and expects the new contents to appear on the following cycle. A long random stream then draws both addresses from a small PC pool that shares indexes, so same-entry collisions and tag aliasing occur often. Each cycle is compared against a behavioural model that applies its update only after it has checked the lookup.

// File: rtl/btb_pkg.sv
package btb_pkg;

    // Classification of one resolve report
    typedef enum logic [2:0] {
        RES_IDLE     = 3'd0,
        RES_SEQ_OK   = 3'd1,
        RES_HIT_OK   = 3'd2,
        RES_INSERT   = 3'd3,
        RES_REMOVE   = 3'd4,
        RES_RETARGET = 3'd5
    } res_kind_e;

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [TAG_W-1:0]  tag_o
);
    logic [OFS_W-1:0] ofs_unused;

    assign {tag_o, idx_o, ofs_unused} = pc_i;
endmodule

// File: rtl/btb_tag_match.sv
module btb_tag_match #(
    parameter int TAG_W = 24
) (
    input  logic             ent_valid_i,
    input  logic [TAG_W-1:0] ent_tag_i,
    input  logic [TAG_W-1:0] pc_tag_i,
    output logic             match_o
);
    always_comb begin
        match_o = ent_valid_i && (ent_tag_i == pc_tag_i);
    end
endmodule

// File: rtl/btb_resolve_classify.sv
module btb_resolve_classify
    import btb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              taken_i,
    input  logic [ADDR_W-1:0] target_i,
    input  logic              pred_hit_i,
    input  logic [ADDR_W-1:0] pred_target_i,
    output res_kind_e         kind_o,
    output logic              flush_o,
    output logic [ADDR_W-1:0] redirect_o
);
    always_comb begin
        kind_o = RES_IDLE;
        if (valid_i) begin
            if (pred_hit_i) begin
                if (!taken_i)                       kind_o = RES_REMOVE;
                else if (target_i == pred_target_i) kind_o = RES_HIT_OK;
                else                                kind_o = RES_RETARGET;
            end else begin
                kind_o = taken_i ? RES_INSERT : RES_SEQ_OK;
            end
        end
        flush_o    = (kind_o == RES_INSERT) || (kind_o == RES_REMOVE) ||
                     (kind_o == RES_RETARGET);
        redirect_o = taken_i ? target_i : (pc_i + ADDR_W'(INSTR_BYTES));
    end
endmodule

// File: rtl/btb_fetch_predictor.sv
module btb_fetch_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ENTRIES     = 64,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              lookup_hit,
    output logic [ADDR_W-1:0] next_pc,
    input  logic              resolve_valid,
    input  logic [ADDR_W-1:0] resolve_pc,
    input  logic              resolve_taken,
    input  logic [ADDR_W-1:0] resolve_target,
    input  logic              resolve_pred_hit,
    input  logic [ADDR_W-1:0] resolve_pred_target,
    output logic              flush,
    output logic [ADDR_W-1:0] redirect_pc
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int OFS_W = $clog2(INSTR_BYTES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] target;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] tbl;
    } state_t;

    state_t state_d, state_q;

    // Address split for the two ports: index 0 fetch, index 1 resolve
    logic [1:0][ADDR_W-1:0] port_pc;
    logic [1:0][IDX_W-1:0]  port_idx;
    logic [1:0][TAG_W-1:0]  port_tag;
    logic [1:0]             port_match;

    assign port_pc[0] = fetch_pc;
    assign port_pc[1] = resolve_pc;

    for (genvar p = 0; p < 2; p++) begin : g_port
        btb_pc_split #(
            .ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFS_W(OFS_W)
        ) u_split (
            .pc_i (port_pc[p]),
            .idx_o(port_idx[p]),
            .tag_o(port_tag[p])
        );
        btb_tag_match #(.TAG_W(TAG_W)) u_match (
            .ent_valid_i(state_q.tbl[port_idx[p]].valid),
            .ent_tag_i  (state_q.tbl[port_idx[p]].tag),
            .pc_tag_i   (port_tag[p]),
            .match_o    (port_match[p])
        );
    end

    res_kind_e res_kind;

    btb_resolve_classify #(
        .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)
    ) u_classify (
        .valid_i      (resolve_valid),
        .pc_i         (resolve_pc),
        .taken_i      (resolve_taken),
        .target_i     (resolve_target),
        .pred_hit_i   (resolve_pred_hit),
        .pred_target_i(resolve_pred_target),
        .kind_o       (res_kind),
        .flush_o      (flush),
        .redirect_o   (redirect_pc)
    );

    // Lookup reads registered state only: updates land after it
    always_comb begin
        lookup_hit = port_match[0];
        next_pc    = port_match[0] ? state_q.tbl[port_idx[0]].target
                                   : (fetch_pc + ADDR_W'(INSTR_BYTES));
    end

    always_comb begin
        state_d = state_q;
        unique case (res_kind)
            RES_INSERT, RES_RETARGET: begin
                state_d.tbl[port_idx[1]].valid  = 1'b1;
                state_d.tbl[port_idx[1]].tag    = port_tag[1];
                state_d.tbl[port_idx[1]].target = resolve_target;
            end
            RES_REMOVE: begin
                if (port_match[1]) state_d.tbl[port_idx[1]].valid = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/btb_fetch_predictor_chk.sv
module btb_fetch_predictor_chk #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              lookup_hit,
    input logic [ADDR_W-1:0] next_pc,
    input logic              resolve_valid,
    input logic [ADDR_W-1:0] resolve_pc,
    input logic              resolve_taken,
    input logic [ADDR_W-1:0] resolve_target,
    input logic              resolve_pred_hit,
    input logic [ADDR_W-1:0] resolve_pred_target,
    input logic              flush,
    input logic [ADDR_W-1:0] redirect_pc
);
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_hit |-> next_pc == fetch_pc + ADDR_W'(INSTR_BYTES));

    a_r5_insert_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && resolve_taken && !resolve_pred_hit) |=>
        (!(fetch_pc == $past(resolve_pc)) ||
         (lookup_hit && next_pc == $past(resolve_target))));

    a_r6_remove_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && !resolve_taken && resolve_pred_hit) |=>
        (!(fetch_pc == $past(resolve_pc)) || !lookup_hit));

    a_r7_correct_no_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (resolve_valid && resolve_pred_hit && resolve_taken &&
         resolve_target == resolve_pred_target) |-> !flush);

    a_r8_taken_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && resolve_taken) |-> redirect_pc == resolve_target);

    a_r11_flush_needs_resolve: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> resolve_valid);
endmodule

bind btb_fetch_predictor btb_fetch_predictor_chk #(
    .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .fetch_pc           (fetch_pc),
    .lookup_hit         (lookup_hit),
    .next_pc            (next_pc),
    .resolve_valid      (resolve_valid),
    .resolve_pc         (resolve_pc),
    .resolve_taken      (resolve_taken),
    .resolve_target     (resolve_target),
    .resolve_pred_hit   (resolve_pred_hit),
    .resolve_pred_target(resolve_pred_target),
    .flush              (flush),
    .redirect_pc        (redirect_pc)
);

// File: tb/btb_fetch_predictor_test.sv
module btb_fetch_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        lookup_hit;
    logic [31:0] next_pc;
    logic        resolve_valid = 1'b0;
    logic [31:0] resolve_pc = '0;
    logic        resolve_taken = 1'b0;
    logic [31:0] resolve_target = '0;
    logic        resolve_pred_hit = 1'b0;
    logic [31:0] resolve_pred_target = '0;
    logic        flush;
    logic [31:0] redirect_pc;

    int n_tests = 0;
    int n_fail  = 0;

    // Behavioural model: per index a valid flag, owning PC and target
    bit          m_valid [64];
    logic [31:0] m_pc    [64];
    logic [31:0] m_tgt   [64];

    always #4 clk = ~clk;  // 125 MHz

    btb_fetch_predictor uut (.*);

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic int idx_of(logic [31:0] pc);
        return int'(pc[7:2]);
    endfunction

    task automatic step(string tag, logic [31:0] fpc, logic rv, logic [31:0] rpc,
                        logic rt, logic [31:0] rtgt, logic ph, logic [31:0] ptgt);
        bit          e_hit;
        logic [31:0] e_next;
        bit          e_flush;
        string       lk_req;
        string       rs_req;
        int          fi;
        int          ri;
        @(negedge clk);
        fetch_pc = fpc; resolve_valid = rv; resolve_pc = rpc; resolve_taken = rt;
        resolve_target = rtgt; resolve_pred_hit = ph; resolve_pred_target = ptgt;
        #2;
        fi     = idx_of(fpc);
        e_hit  = m_valid[fi] && (m_pc[fi][31:8] == fpc[31:8]);
        e_next = e_hit ? m_tgt[fi] : fpc + 32'd4;
        lk_req = e_hit ? "R4" : "R2";
        if (!rv)                           begin e_flush = 0; rs_req = "R11"; end
        else if (ph && !rt)                begin e_flush = 1; rs_req = "R6";  end
        else if (ph && rtgt == ptgt)       begin e_flush = 0; rs_req = "R7";  end
        else if (ph)                       begin e_flush = 1; rs_req = "R8";  end
        else if (rt)                       begin e_flush = 1; rs_req = "R5";  end
        else                               begin e_flush = 0; rs_req = "R9";  end
        check({tag, "/", lk_req, " hit"}, 32'(lookup_hit), 32'(e_hit));
        check({tag, "/", lk_req, " next_pc"}, next_pc, e_next);
        check({tag, "/", rs_req, " flush"}, 32'(flush), 32'(e_flush));
        if (e_flush)
            check({tag, "/", rs_req, " redirect"}, redirect_pc, rt ? rtgt : rpc + 32'd4);
        @(posedge clk);
        if (rv) begin
            ri = idx_of(rpc);
            if (rt && (!ph || rtgt != ptgt)) begin
                m_valid[ri] = 1; m_pc[ri] = rpc; m_tgt[ri] = rtgt;
            end else if (!rt && ph && m_valid[ri] && m_pc[ri][31:8] == rpc[31:8]) begin
                m_valid[ri] = 0;
            end
        end
    endtask

    task automatic fetch_only(string tag, logic [31:0] fpc);
        step(tag, fpc, 0, 32'h0, 0, 32'h0, 0, 32'h0);
    endtask

    initial begin
        #800000;
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin m_valid[i] = 0; m_pc[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: empty after reset
        fetch_only("R1", 32'h0000_1000);
        fetch_only("R1", 32'h0000_10FC);
        // R5 insert with same-entry lookup in that cycle (R10: old contents seen)
        step("R10", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0, 32'h0);
        fetch_only("R4", 32'h0000_1000);
        // R3 alias: same index, other tag
        fetch_only("R3", 32'h0000_1100);
        fetch_only("R3", 32'h0001_1000);
        // R7 correct hit
        step("R7", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 1, 32'h0000_2000);
        // R8 wrong target
        step("R8", 32'h0000_2000, 1, 32'h0000_1000, 1, 32'h0000_3000, 1, 32'h0000_2000);
        fetch_only("R8", 32'h0000_1000);
        // R6 remove with same-entry lookup (R10)
        step("R10", 32'h0000_1000, 1, 32'h0000_1000, 0, 32'h0, 1, 32'h0000_3000);
        fetch_only("R6", 32'h0000_1000);
        // R9 not predicted, not taken
        step("R9", 32'h0000_2004, 1, 32'h0000_2000, 0, 32'h0, 0, 32'h0);
        // R6 with stale tag: entry for another PC survives
        step("R5", 32'h0000_1000, 1, 32'h0000_1000, 1, 32'h0000_2000, 0, 32'h0);
        step("R6", 32'h0000_1000, 1, 32'h0000_1100, 0, 32'h0, 1, 32'h0000_5000);
        fetch_only("R6", 32'h0000_1000);
        // fill several indexes
        for (int i = 0; i < 8; i++)
            step("R5", 32'h0, 1, 32'h0000_4000 + 32'(4*i), 1, 32'h0000_8000 + 32'(16*i), 0, 32'h0);
        for (int i = 0; i < 8; i++)
            fetch_only("R4", 32'h0000_4000 + 32'(4*i));
        // R11 idle
        repeat (3) fetch_only("R11", 32'h0000_4000);
        // random collision stream over a small pool
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] fpc;
            logic [31:0] rpc;
            logic [31:0] rtg;
            logic [31:0] ptg;
            fpc = {22'h0, 2'(($urandom % 4)), 2'(($urandom % 2)), 4'(($urandom % 4)), 2'b00};
            rpc = ($urandom % 3 == 0) ? fpc
                : {22'h0, 2'(($urandom % 4)), 2'(($urandom % 2)), 4'(($urandom % 4)), 2'b00};
            rtg = 32'h0001_0000 + 32'(4 * ($urandom % 3));
            ptg = 32'h0001_0000 + 32'(4 * ($urandom % 3));
            step("rand", fpc, 1'($urandom % 4 != 0), rpc, 1'($urandom % 2),
                 rtg, 1'($urandom % 2), ptg);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule